// File: doc/BRIEF.md
# Transceiver Mode and Supply Supervisor

This block chooses the operating mode of a high-speed bus transceiver from the standby request pin and two supply undervoltage flags. The three modes are unpowered, standby and normal. From that mode it derives the enables for the line driver, the receive reporting path, the bus bias network, the low-power wake detector and the push-pull stage of the receive-data pin. The priority is fixed. Loss of the I/O supply wins over loss of the driver supply, and loss of the driver supply wins over the standby request pin.

Two timing guards apply on the way into normal mode. The first is a power-up delay that starts after reset or after the I/O supply returns. The second is a settling delay that runs each time the standby request falls. During either delay the block reports standby. Transmission is allowed only when normal mode is actually reported. A strap selects the single-supply variant. On that variant both flags watch the same supply, so the low-threshold flag counts only when the high-threshold flag is also set.

Top module: `xcvr_mode_supervisor`

## Requirements
- R1: While reset is low the mode output is 2'b00 (unpowered) and all five enables are low. On the first clock edge after reset, with both supplies good, the mode becomes 2'b01 (standby).
- R2: With the standby request high and supplies good, the mode is 2'b01. In standby only the wake-detector enable is high. The transmit, receive-report, bias and push-pull enables are low.
- R3: With the request low, supplies good and power-up finished, the mode becomes 2'b10 (normal) exactly NORM_CYCLES clock edges after the request falls, and reads standby before that. In normal mode the transmit, receive-report, bias and push-pull enables are high and the wake-detector enable is low.
- R4: If the request rises during the settling delay, the next edge gives standby. A later fall restarts the full NORM_CYCLES delay.
- R5: A rising request while in normal mode gives standby on the next edge.
- R6: A driver-supply undervoltage flag forces standby on the next edge, whatever the request. The wake-detector enable stays high. While the flag is set, normal mode cannot be reached. Clearing the flag does not restart the power-up delay.
- R7: On the dual-supply variant (strap 0), an I/O-supply undervoltage flag forces 2'b00 on the next edge, whatever the other inputs. All enables go low.
- R8: On the single-supply variant (strap 1), the I/O flag has an effect only together with the driver flag. The I/O flag alone leaves the mode unchanged. Driver flag alone gives standby; both flags give unpowered.
- R9: After reset release, or after leaving unpowered, normal mode is reached no earlier than PWRUP_CYCLES + NORM_CYCLES edges, and exactly then if the request is low throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stby_req_i | input | 1 | Standby request, 1 = standby (pin pulled high when open) |
| vdd_uv_i | input | 1 | Driver supply below its undervoltage threshold |
| vio_uv_i | input | 1 | I/O supply below its undervoltage threshold |
| single_supply_i | input | 1 | Strap, 1 = I/O supply tied to driver supply |
| mode_o | output | 2 | 00 unpowered, 01 standby, 10 normal |
| tx_allow_o | output | 1 | Line driver may follow transmit data |
| rx_report_en_o | output | 1 | Differential receiver reports bus level |
| bias_en_o | output | 1 | Bus bias network enabled |
| wake_det_en_o | output | 1 | Low-power wake detector enabled |
| rxd_pp_en_o | output | 1 | Receive-data push-pull stage enabled |

## Verification
The mode is held in one register and the enables are decoded from it without further delay. Every input change therefore shows on all outputs after exactly one clock edge, except the entries into normal mode. Those take NORM_CYCLES edges after the request falls, or PWRUP_CYCLES + NORM_CYCLES edges after reset or after the I/O supply returns. The bench drives inputs and samples outputs on falling edges. It counts rising edges from each stimulus, and checks one edge before and exactly at each delayed boundary, so an off-by-one in either counter is seen.

// File: rtl/xcvr_mode_pkg.sv
// Shared mode encoding and enable bundle for the transceiver mode supervisor.
package xcvr_mode_pkg;

    typedef enum logic [1:0] {
        XMS_UNPWR = 2'b00,
        XMS_STBY  = 2'b01,
        XMS_NORM  = 2'b10
    } xms_mode_e;

    typedef struct packed {
        logic tx_allow;
        logic rx_report;
        logic bias;
        logic wake_det;
        logic rxd_pp;
    } xms_en_t;

endpackage

// File: rtl/xms_ready_timer.sv
// Power-up readiness timer.
// Counts clock edges while the I/O supply is present and flags ready after
// PWRUP_CYCLES of them. Any supply loss clears it. Assumes PWRUP_CYCLES >= 1.
module xms_ready_timer #(
    parameter int PWRUP_CYCLES = 37500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_lost_i,
    output logic ready_o
);
    localparam int CW = $clog2(PWRUP_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(PWRUP_CYCLES);

    logic [CW-1:0] cnt_q;

    // Count up to the limit while powered, restart on loss.
    always_ff @(posedge clk) begin
        if (!rst_n || supply_lost_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign ready_o = (cnt_q == LAST);

    // A supply loss must drop readiness on the following edge.
    assert_loss_clears_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        supply_lost_i |=> !ready_o);
endmodule

// File: rtl/xms_mode_ctrl.sv
// Mode register with the standby-to-normal settling delay.
// Takes the already-prioritised requests. Unpowered wins over standby.
// Normal is entered only after NORM_CYCLES consecutive edges of a clean
// normal request. Assumes NORM_CYCLES >= 1.
module xms_mode_ctrl
    import xcvr_mode_pkg::*;
#(
    parameter int NORM_CYCLES = 5000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      unpwr_req_i,
    input  logic      stby_req_i,
    input  logic      ready_i,
    output xms_mode_e mode_o
);
    localparam int NW = $clog2(NORM_CYCLES + 1);
    localparam logic [NW-1:0] LAST = NW'(NORM_CYCLES - 1);

    xms_mode_e     mode_q;
    logic [NW-1:0] cnt_q;
    logic          norm_req;

    // Normal is requested only when nothing forces a lower mode.
    always_comb norm_req = !unpwr_req_i && !stby_req_i && ready_i;

    // Mode update and settling counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= XMS_UNPWR;
            cnt_q  <= '0;
        end else if (unpwr_req_i) begin
            mode_q <= XMS_UNPWR;
            cnt_q  <= '0;
        end else if (!norm_req) begin
            mode_q <= XMS_STBY;
            cnt_q  <= '0;
        end else if (mode_q != XMS_NORM) begin
            if (cnt_q == LAST) begin
                mode_q <= XMS_NORM;
                cnt_q  <= '0;
            end else begin
                mode_q <= XMS_STBY;
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    assign mode_o = mode_q;

    // Normal is never reported before the settling count completes.
    assert_entry_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != XMS_NORM && cnt_q != LAST) |=> mode_q != XMS_NORM);

    // Normal mode needs the power-up timer to be done.
    assert_norm_needs_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == XMS_NORM) |-> ready_i);
endmodule

// File: rtl/xms_enable_map.sv
// Maps the mode to the analog enables. Purely combinational.
// An undefined mode code maps to all enables off.
module xms_enable_map
    import xcvr_mode_pkg::*;
(
    input  xms_mode_e mode_i,
    output xms_en_t   en_o
);
    // One enable set per mode.
    always_comb begin
        en_o = '0;
        case (mode_i)
            XMS_NORM: begin
                en_o.tx_allow  = 1'b1;
                en_o.rx_report = 1'b1;
                en_o.bias      = 1'b1;
                en_o.rxd_pp    = 1'b1;
            end
            XMS_STBY:  en_o.wake_det = 1'b1;
            default:   en_o = '0;
        endcase
    end
endmodule

// File: rtl/xcvr_mode_supervisor.sv
// Transceiver mode and supply supervisor, top level.
// Prioritises I/O supply loss, driver supply loss and the standby request,
// gates normal entry with power-up and settling delays, and drives the enables.
// Assumes all inputs are already synchronous to clk.
module xcvr_mode_supervisor
    import xcvr_mode_pkg::*;
#(
    parameter int PWRUP_CYCLES = 37500,
    parameter int NORM_CYCLES  = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stby_req_i,
    input  logic       vdd_uv_i,
    input  logic       vio_uv_i,
    input  logic       single_supply_i,
    output logic [1:0] mode_o,
    output logic       tx_allow_o,
    output logic       rx_report_en_o,
    output logic       bias_en_o,
    output logic       wake_det_en_o,
    output logic       rxd_pp_en_o
);
    logic      vio_lost;
    logic      ready;
    xms_mode_e mode;
    xms_en_t   en;

    // On one supply the low flag is only credible together with the high one.
    always_comb vio_lost = vio_uv_i && (!single_supply_i || vdd_uv_i);

    xms_ready_timer #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_ready (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_lost_i(vio_lost),
        .ready_o      (ready)
    );

    xms_mode_ctrl #(.NORM_CYCLES(NORM_CYCLES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .unpwr_req_i(vio_lost),
        .stby_req_i (stby_req_i || vdd_uv_i),
        .ready_i    (ready),
        .mode_o     (mode)
    );

    xms_enable_map u_map (
        .mode_i(mode),
        .en_o  (en)
    );

    assign mode_o         = mode;
    assign tx_allow_o     = en.tx_allow;
    assign rx_report_en_o = en.rx_report;
    assign bias_en_o      = en.bias;
    assign wake_det_en_o  = en.wake_det;
    assign rxd_pp_en_o    = en.rxd_pp;

    // Dual-supply I/O loss gives unpowered on the next edge.
    assert_vio_unpowered_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vio_uv_i && !single_supply_i) |=> (mode_o == 2'b00 && !wake_det_en_o));

    // Driver-supply loss alone gives standby with wake detection.
    assert_vdd_standby_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vdd_uv_i && !vio_uv_i) |=> (mode_o == 2'b01 && wake_det_en_o));

    // Standby request with good supplies ends normal at once.
    assert_stby_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stby_req_i && !vdd_uv_i && !vio_uv_i) |=> (mode_o == 2'b01 && !tx_allow_o));

    // Single supply: a lone I/O flag never yields unpowered.
    assert_single_lone_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (single_supply_i && vio_uv_i && !vdd_uv_i) |=> mode_o != 2'b00);

    // The mode code stays within the three defined values.
    assert_mode_legal_R1: assert property (@(posedge clk) mode_o != 2'b11);
endmodule

// File: tb/tb_xcvr_mode_supervisor.sv
module tb_xcvr_mode_supervisor;
    localparam int P = 20;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stby = 1'b1, vdd_uv = 1'b0, vio_uv = 1'b0, ss = 1'b0;
    logic [1:0] mode;
    logic tx, rxr, bias, wake, pp;
    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    xcvr_mode_supervisor #(.PWRUP_CYCLES(P), .NORM_CYCLES(N)) dut (
        .clk(clk), .rst_n(rst_n), .stby_req_i(stby), .vdd_uv_i(vdd_uv),
        .vio_uv_i(vio_uv), .single_supply_i(ss), .mode_o(mode),
        .tx_allow_o(tx), .rx_report_en_o(rxr), .bias_en_o(bias),
        .wake_det_en_o(wake), .rxd_pp_en_o(pp)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Compare mode and the enable set implied by it.
    task automatic expect_mode(input string req, input logic [1:0] m);
        logic [4:0] exp_en, act_en;
        exp_en = (m == 2'b10) ? 5'b11101 : (m == 2'b01) ? 5'b00010 : 5'b00000;
        act_en = {tx, rxr, bias, wake, pp};
        n_chk++;
        if (mode !== m || act_en !== exp_en) begin
            n_fail++;
            $display("FAIL %s: mode=%b en=%b expected mode=%b en=%b", req, mode, act_en, m, exp_en);
        end
    endtask

    task automatic t_reset_state;
        rst_n = 1'b0; stby = 1'b1; tick(3);
        expect_mode("R1 in reset", 2'b00);
        rst_n = 1'b1; tick(1);
        expect_mode("R1 first edge", 2'b01);
        tick(P + N + 5);
        expect_mode("R2 standby held", 2'b01);
    endtask

    task automatic t_powerup;
        rst_n = 1'b0; stby = 1'b0; tick(2);
        rst_n = 1'b1; tick(P + N - 1);
        expect_mode("R9 before power-up end", 2'b01);
        tick(1);
        expect_mode("R9 R3 normal reached", 2'b10);
    endtask

    task automatic t_settle;
        stby = 1'b1; tick(1);
        expect_mode("R5 exit normal", 2'b01);
        stby = 1'b0; tick(N - 1);
        expect_mode("R3 one edge early", 2'b01);
        tick(1);
        expect_mode("R3 normal on time", 2'b10);
    endtask

    task automatic t_abort;
        stby = 1'b1; tick(1);
        stby = 1'b0; tick(3);
        stby = 1'b1; tick(1);
        expect_mode("R4 abort to standby", 2'b01);
        stby = 1'b0; tick(N - 1);
        expect_mode("R4 delay restarted", 2'b01);
        tick(1);
        expect_mode("R4 normal after full delay", 2'b10);
    endtask

    task automatic t_vdd;
        vdd_uv = 1'b1; tick(1);
        expect_mode("R6 vdd loss", 2'b01);
        tick(20);
        expect_mode("R6 vdd loss held", 2'b01);
        vdd_uv = 1'b0; tick(N - 1);
        expect_mode("R6 recovery delay", 2'b01);
        tick(1);
        expect_mode("R6 normal without power-up", 2'b10);
    endtask

    task automatic t_vio;
        vio_uv = 1'b1; vdd_uv = 1'b1; tick(1);
        expect_mode("R7 vio loss", 2'b00);
        vdd_uv = 1'b0; tick(2);
        expect_mode("R7 vio loss priority", 2'b00);
        vio_uv = 1'b0; tick(1);
        expect_mode("R7 vio back", 2'b01);
        tick(P + N - 2);
        expect_mode("R9 after vio, early", 2'b01);
        tick(1);
        expect_mode("R9 after vio, normal", 2'b10);
    endtask

    task automatic t_single;
        ss = 1'b1; vio_uv = 1'b1; vdd_uv = 1'b0; tick(3);
        expect_mode("R8 lone vio flag ignored", 2'b10);
        vdd_uv = 1'b1; tick(1);
        expect_mode("R8 both flags", 2'b00);
        vio_uv = 1'b0; tick(1);
        expect_mode("R8 vdd band standby", 2'b01);
        vdd_uv = 1'b0; ss = 1'b0;
    endtask

    initial begin
        fork
            begin
                t_reset_state();
                t_powerup();
                t_settle();
                t_abort();
                t_vdd();
                t_vio();
                t_single();
            end
            begin
                tick(20000);
                n_chk++; n_fail++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule